// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a calendar timekeeper for a larger chip. It keeps eight packed-BCD fields: century, two-digit year, month, date, day of week, hour (24-hour), minute and second. A prescaler divides a slow oscillator tick, nominally 32.768 kHz, down to one advance per second. Within that single step the block carries through every field. It corrects the month length, and it treats every year divisible by four as a leap year, which gives the right answer up to the year 2100.

The block holds two copies of the time. The working copy advances every second and never stops. The visible copy follows the working copy on each clock while the `hold` input is low. A host raises `hold` to freeze the visible copy so that it can read a consistent snapshot. While `hold` is high, the host may also write fields of the visible copy. When `hold` falls after one or more writes, the written values replace the working copy and the prescaler restarts, so that the new time begins on a full second boundary.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset both copies read 20 (century), 00 (year), 01 (month), 01 (date), 1 (day), 00:00:00. All fields are packed BCD with the tens digit in bits 7:4. The field addresses are: 0 second, 1 minute, 2 hour, 3 day of week, 4 date, 5 month, 6 year, 7 century.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23. Each field that rolls over carries into the next field within the same one-second step.
- R3: Date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. Month rolls from 12 to 01.
- R4: February ends on 29 when the year is divisible by four (year 00 included) and on 28 otherwise.
- R5: Day of week counts 1 to 7 and advances at each midnight, wrapping from 7 to 1.
- R6: When the year rolls from 99 to 00, the century increments in BCD.
- R7: The working copy advances once every PRESCALE `osc_tick` pulses, whatever the level of `hold`.
- R8: While `hold` is high the visible copy does not change except through host writes. While `hold` is low, the visible copy equals the working copy one clock later.
- R9: A write with `hold` high updates the addressed visible field. The first clock with `hold` low after such writes loads the visible copy into the working copy and clears the prescaler, so the next second passes after a full PRESCALE pulses.
- R10: A write with `hold` low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| hold | input | 1 | Freeze the visible copy and allow host writes |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Field address |
| wdata | input | 8 | Write data, packed BCD |
| rdata | output | 8 | Visible-copy field selected by `addr` |

## Verification
The hardest case to reach from the ports is a prescaler restart after a partial second. To set it up, the bench first delivers some oscillator pulses that leave the prescaler part-way through a second. It then raises `hold`, writes a field and releases `hold`. From that point it counts exactly PRESCALE-1 pulses and checks that the seconds field has not moved, then gives one more pulse and checks that it has. To bring the calendar to edges such as 31 December 99, 28 February of a leap year, or Saturday midnight, the bench writes a time just before the edge. This avoids waiting through days of simulated seconds.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] wday;
      logic [7:0] hour;
      logic [7:0] min;
      logic [7:0] sec;
   } cal_time_t;

   localparam int unsigned FIELD_W  = 8;
   localparam int unsigned FIELD_N  = 8;
   localparam int unsigned ADDR_W   = $clog2(FIELD_N);

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9)
         return (v[7:4] == 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'd0};
      else
         return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic yr_div4(input logic [7:0] y);
      if (y[4] == 1'b0)
         return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else
         return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   function automatic logic [7:0] last_date(input logic [7:0] mo, input logic [7:0] y);
      case (mo)
         8'h02:                      return yr_div4(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   input  logic clear,
   output logic sec_pulse
);
   localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (PRESCALE < 1) begin : g_bad
         $error("PRESCALE must be at least 1");
      end

      if (PRESCALE == 1) begin : g_pass
         assign sec_pulse = osc_tick & ~clear;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          at_end;

         assign at_end    = (cnt_q == CW'(PRESCALE - 1));
         assign sec_pulse = osc_tick & at_end & ~clear;

         always_ff @(posedge clk) begin
            if (!rst_n || clear)
               cnt_q <= '0;
            else if (osc_tick)
               cnt_q <= at_end ? '0 : cnt_q + CW'(1);
         end

         a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CW'(PRESCALE - 1));
      end
   endgenerate
endmodule

// File: rtl/cal_advance.sv
module cal_advance
   import cal_pkg::*;
(
   input  cal_time_t cur,
   output cal_time_t nxt
);
   logic c_sec, c_min, c_hr, c_date, c_mon, c_yr;

   always_comb begin
      nxt    = cur;
      c_sec  = (cur.sec  == 8'h59);
      c_min  = (cur.min  == 8'h59);
      c_hr   = (cur.hour == 8'h23);
      c_date = (cur.date == last_date(cur.month, cur.year));
      c_mon  = (cur.month == 8'h12);
      c_yr   = (cur.year == 8'h99);

      nxt.sec = c_sec ? 8'h00 : bcd_inc(cur.sec);
      if (c_sec) begin
         nxt.min = c_min ? 8'h00 : bcd_inc(cur.min);
         if (c_min) begin
            nxt.hour = c_hr ? 8'h00 : bcd_inc(cur.hour);
            if (c_hr) begin
               nxt.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_inc(cur.wday);
               nxt.date = c_date ? 8'h01 : bcd_inc(cur.date);
               if (c_date) begin
                  nxt.month = c_mon ? 8'h01 : bcd_inc(cur.month);
                  if (c_mon) begin
                     nxt.year = bcd_inc(cur.year);
                     if (c_yr)
                        nxt.cent = bcd_inc(cur.cent);
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
   import cal_pkg::*;
#(
   parameter cal_time_t RST_TIME = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [FIELD_W-1:0] wdata,
   input  cal_time_t         work,
   output cal_time_t         vis,
   output logic              load,
   output logic [FIELD_W-1:0] rdata
);
   logic hold_q, dirty_q;
   logic [FIELD_N*FIELD_W-1:0] vis_flat;

   assign load     = hold_q & ~hold & dirty_q;
   assign vis_flat = vis;
   assign rdata    = vis_flat[addr*FIELD_W +: FIELD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vis     <= RST_TIME;
         hold_q  <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         hold_q <= hold;
         if (load)
            dirty_q <= 1'b0;
         else if (hold && wr_en)
            dirty_q <= 1'b1;

         if (load) begin
            vis <= vis;
         end else if (!hold) begin
            vis <= work;
         end else if (wr_en) begin
            case (addr)
               3'd0: vis.sec   <= wdata;
               3'd1: vis.min   <= wdata;
               3'd2: vis.hour  <= wdata;
               3'd3: vis.wday  <= wdata;
               3'd4: vis.date  <= wdata;
               3'd5: vis.month <= wdata;
               3'd6: vis.year  <= wdata;
               default: vis.cent <= wdata;
            endcase
         end
      end
   end

   // R8: frozen copy moves only through host writes
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !wr_en) |=> (!hold || $stable(vis)));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
   import cal_pkg::*;
#(
   parameter int unsigned PRESCALE      = 32768,
   parameter logic [7:0]  RESET_CENTURY = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       hold,
   input  logic       wr_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);
   localparam cal_time_t RST_TIME = '{cent: RESET_CENTURY, year: 8'h00, month: 8'h01,
                                      date: 8'h01, wday: 8'h01, hour: 8'h00,
                                      min: 8'h00, sec: 8'h00};

   cal_time_t work_q, work_nxt, vis;
   logic      sec_pulse, load;

   cal_prescaler #(.PRESCALE(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .clear(load), .sec_pulse(sec_pulse));

   cal_advance u_adv (.cur(work_q), .nxt(work_nxt));

   cal_shadow #(.RST_TIME(RST_TIME)) u_shadow (
      .clk(clk), .rst_n(rst_n), .hold(hold), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .work(work_q), .vis(vis), .load(load), .rdata(rdata));

   always_ff @(posedge clk) begin
      if (!rst_n)
         work_q <= RST_TIME;
      else if (load)
         work_q <= vis;
      else if (sec_pulse)
         work_q <= work_nxt;
   end

   // R7: every second pulse changes the working copy
   a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !load) |=> (work_q != $past(work_q)));

   // R9: release after writes transfers the visible copy
   a_r9_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (work_q == $past(vis)));

   // R2: seconds rollover clears seconds and moves minutes
   a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !load && work_q.sec == 8'h59) |=>
         (work_q.sec == 8'h00 && work_q.min != $past(work_q.min)));

   // R5: day-of-week stays in 1..7 while counting
   a_r5_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && !load && work_q.wday >= 8'h01 && work_q.wday <= 8'h07) |=>
         (work_q.wday >= 8'h01 && work_q.wday <= 8'h07));
endmodule

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;
   localparam int P = 4;

   logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, hold = 1'b0, wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bcd_calendar_clock #(.PRESCALE(P)) i_bcd_calendar_clock (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .hold(hold), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) osc_tick = 1'b1;
         @(negedge clk) osc_tick = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; addr = a; wdata = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
      addr = a;
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_bad++;
         $display("FAIL %s field %0d: got %h expected %h", req, a, rdata, exp);
      end
   endtask

   task automatic set_time(input logic [7:0] c, y, mo, d, wd, h, mi, s);
      @(negedge clk) hold = 1'b1;
      wr(0, s); wr(1, mi); wr(2, h); wr(3, wd);
      wr(4, d); wr(5, mo); wr(6, y); wr(7, c);
      @(negedge clk) hold = 1'b0;
      settle();
   endtask

   task automatic chk_all(input logic [7:0] c, y, mo, d, wd, h, mi, s, input string req);
      chk(0, s, req); chk(1, mi, req); chk(2, h, req); chk(3, wd, req);
      chk(4, d, req); chk(5, mo, req); chk(6, y, req); chk(7, c, req);
   endtask

   task automatic t_reset();
      chk_all(8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset");
   endtask

   task automatic t_midnight();
      set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
      chk_all(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58, "R9 write load");
      pulses(P); settle();
      chk(0, 8'h59, "R2 seconds step");
      pulses(P); settle();
      chk_all(8'h20, 8'h23, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00,
              "R2 R3 R5 midnight non-leap Feb");
   endtask

   task automatic t_leap();
      set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk(4, 8'h29, "R4 leap 24 date"); chk(5, 8'h02, "R4 leap 24 month");
      set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk(4, 8'h01, "R4 end Feb 29"); chk(5, 8'h03, "R4 march");
      set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk(4, 8'h29, "R4 year 00 leap");
   endtask

   task automatic t_months();
      set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk(4, 8'h01, "R3 30-day date"); chk(5, 8'h05, "R3 30-day month");
      set_time(8'h20, 8'h23, 8'h01, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk(4, 8'h31, "R3 31-day date"); chk(5, 8'h01, "R3 31-day month");
   endtask

   task automatic t_century();
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
      pulses(P); settle();
      chk_all(8'h21, 8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00, "R6 century roll");
   endtask

   task automatic t_freeze();
      set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h02, 8'h12, 8'h00, 8'h00);
      @(negedge clk) hold = 1'b1;
      pulses(3 * P); settle();
      chk(0, 8'h00, "R8 frozen seconds");
      @(negedge clk) hold = 1'b0;
      settle();
      chk(0, 8'h03, "R7 counted during hold");
   endtask

   task automatic t_subcount();
      set_time(8'h20, 8'h23, 8'h06, 8'h15, 8'h02, 8'h12, 8'h00, 8'h00);
      pulses(2);
      @(negedge clk) hold = 1'b1;
      wr(0, 8'h10);
      @(negedge clk) hold = 1'b0;
      settle();
      pulses(P - 1); settle();
      chk(0, 8'h10, "R9 prescaler restarted");
      pulses(1); settle();
      chk(0, 8'h11, "R9 full second after load");
   endtask

   task automatic t_ignored();
      wr(0, 8'h45);
      settle();
      chk(0, 8'h11, "R10 write without hold");
      chk(1, 8'h00, "R10 other field");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_midnight();
      t_leap();
      t_months();
      t_century();
      t_freeze();
      t_subcount();
      t_ignored();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule